// File: doc/BRIEF.md
# Inter-processor mailbox slot bank

This block holds a set of mailbox slots that two processors share to pass fixed-length messages. Each slot has one control word and a message area of data words. The control word carries a one-hot channel state and an acknowledge-style bit. Both processors reach the bank through their own word-addressed register port. One port belongs to the application processor and the other to the peer controller. Each port can read and write every slot in the same cycle as the other port.

A sender sets the slot state to transmitting and picks an acknowledge style. It fills the data words and then signals its peer through a separate interrupt block. The receiver reads the message and returns the slot to idle. In automatic style the bank returns the slot to idle by itself once the peer port has read the last data word. A per-slot pulse reports each return to idle, so a poller or the interrupt logic can see that the previous send is complete.

Top module: `mbx_slot_bank`

## Requirements
- R1: After reset, every slot's control word reads 0x0000_0010 (state idle, mode 0), every data word reads zero, both read-data outputs are zero and `idle_evt` is zero.
- R2: Word address = slot × 16 + offset. Offset 0 is the control word and offsets 1 to 8 are data words 0 to 7. A read request returns its data on the read-data output at the next rising edge. Read data holds its value until the next read on that port.
- R3: The control word has the state in bits [7:4], one-hot: 0x1 idle, 0x2 transmitting, 0x4 receiving, 0x8 acknowledged. Bit 0 is the mode: 1 means automatic, 0 means acknowledge by interrupt. All other bits read zero and are dropped on write.
- R4: A control-word write always updates the mode bit from bit 0. If bits [7:4] are not one-hot, the state is left unchanged. A read-modify-write of one field therefore leaves the other field as it was.
- R5: Either port can write any data word and either port can read it back.
- R6: Offsets 9 to 15, and slot numbers at or above the slot count, read zero and ignore writes.
- R7: In automatic mode, a peer-port read of data word 7 (offset 8) sets the slot state to idle, visible one cycle later. An application-port read of that word has no such effect, and neither does any read in interrupt mode.
- R8: A control-word write to a slot in the same cycle as its automatic return to idle takes precedence over the return to idle.
- R9: When both ports write the same word in one cycle, the application port's value is kept. For the control word this priority applies to each field separately, and a non-one-hot state field does not count as a write.
- R10: `idle_evt[n]` is high for one cycle, in the first cycle in which slot n reads idle after having held another state.
- R11: An access to one slot never changes another slot's state, mode or data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ap_req | input | 1 | Application port access request |
| ap_we | input | 1 | Application port write (1) or read (0) |
| ap_addr | input | ADDR_W | Application port word address |
| ap_wdata | input | 32 | Application port write data |
| ap_rdata | output | 32 | Application port read data, registered |
| pr_req | input | 1 | Peer port access request |
| pr_we | input | 1 | Peer port write (1) or read (0) |
| pr_addr | input | ADDR_W | Peer port word address |
| pr_wdata | input | 32 | Peer port write data |
| pr_rdata | output | 32 | Peer port read data, registered |
| idle_evt | output | NUM_SLOTS | Per-slot pulse on each return to idle |

## Verification
Every result of this bank is due one edge after its cause. Read data appears at the rising edge that samples the request. A state, mode or data change made by a write or by a peer read of the last word is visible to a read issued in the following cycle. The idle pulse rises at the same edge as the new idle state. The bench holds a behavioural model that it updates at each rising edge from the inputs that edge samples. It compares both read outputs and the idle pulses against that model at every falling edge, so each result is checked in the exact cycle it is due and in no other.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the mailbox slot bank.
// Assumes 32-bit words; the control word layout is fixed by software.
package mbx_pkg;

    localparam int WORD_W    = 32;
    localparam int STATE_LSB = 4;
    localparam int MODE_POS  = 0;

    typedef enum logic [3:0] {
        ST_IDLE = 4'b0001,
        ST_TX   = 4'b0010,
        ST_RX   = 4'b0100,
        ST_ACK  = 4'b1000
    } mbx_state_e;

    // Build the read image of a control word from its two fields.
    function automatic logic [WORD_W-1:0] ctl_image(logic [3:0] st, logic md);
        logic [WORD_W-1:0] w;
        w = '0;
        w[STATE_LSB +: 4] = st;
        w[MODE_POS]       = md;
        return w;
    endfunction

endpackage

// File: rtl/mbx_decode.sv
`timescale 1ns/1ps
// Address decoder for one register port of the mailbox bank.
// Splits a word address into slot select and in-slot offset, and
// classifies the offset as control, data or unused.
// Assumes MSG_WORDS < SLOT_WORDS and SLOT_WORDS a power of two.
module mbx_decode #(
    parameter int NUM_SLOTS  = 2,
    parameter int SLOT_WORDS = 16,
    parameter int MSG_WORDS  = 8,
    parameter int ADDR_W     = 5,
    parameter int IDX_W      = 3
) (
    input  logic                 req,
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_SLOTS-1:0] slot_sel,
    output logic                 ctl_hit,
    output logic                 dat_hit,
    output logic                 last_hit,
    output logic [IDX_W-1:0]     dat_idx,
    output logic                 unmapped
);

    localparam int OFS_W = $clog2(SLOT_WORDS);
    localparam int SEL_W = ADDR_W - OFS_W;

    logic [OFS_W-1:0] ofs;
    logic [SEL_W-1:0] sidx;
    logic             in_range;

    assign ofs      = addr[OFS_W-1:0];
    assign sidx     = addr[ADDR_W-1:OFS_W];
    assign in_range = (int'(sidx) < NUM_SLOTS);

    // Offset classification
    assign ctl_hit  = (ofs == '0);
    assign dat_hit  = (ofs != '0) && (int'(ofs) <= MSG_WORDS);
    assign last_hit = (int'(ofs) == MSG_WORDS);
    assign dat_idx  = IDX_W'(int'(ofs) - 1);
    assign unmapped = !in_range || !(ctl_hit || dat_hit);

    // One select line per slot, qualified by the request
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_sel
        assign slot_sel[g] = req && in_range && (int'(sidx) == g);
    end

endmodule

// File: rtl/mbx_slot.sv
`timescale 1ns/1ps
// One mailbox slot: one-hot state, acknowledge-mode bit and message words.
// Port A (application) has priority over port B (peer) on the same word.
// auto_rd is a peer read of the last data word of this slot.
module mbx_slot
    import mbx_pkg::*;
#(
    parameter int MSG_WORDS = 8,
    parameter int IDX_W     = 3
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                a_ctl_we,
    input  logic                                a_dat_we,
    input  logic [IDX_W-1:0]                    a_idx,
    input  logic [WORD_W-1:0]                   a_wdata,
    input  logic                                b_ctl_we,
    input  logic                                b_dat_we,
    input  logic [IDX_W-1:0]                    b_idx,
    input  logic [WORD_W-1:0]                   b_wdata,
    input  logic                                auto_rd,
    output logic [3:0]                          state_q,
    output logic                                mode_q,
    output logic [MSG_WORDS-1:0][WORD_W-1:0]    data_q,
    output logic                                idle_evt
);

    logic       a_st_ok, b_st_ok;
    logic [3:0] state_nx;
    logic       mode_nx;

    assign a_st_ok = a_ctl_we && $onehot(a_wdata[STATE_LSB +: 4]);
    assign b_st_ok = b_ctl_we && $onehot(b_wdata[STATE_LSB +: 4]);

    // Next state: explicit writes first, then automatic return to idle
    always_comb begin
        if (a_st_ok)
            state_nx = a_wdata[STATE_LSB +: 4];
        else if (b_st_ok)
            state_nx = b_wdata[STATE_LSB +: 4];
        else if (auto_rd && mode_q && !a_ctl_we && !b_ctl_we)
            state_nx = ST_IDLE;
        else
            state_nx = state_q;
    end

    // Next mode: taken from any control write, port A first
    always_comb begin
        if (a_ctl_we)
            mode_nx = a_wdata[MODE_POS];
        else if (b_ctl_we)
            mode_nx = b_wdata[MODE_POS];
        else
            mode_nx = mode_q;
    end

    // Control registers and the idle pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            mode_q   <= 1'b0;
            idle_evt <= 1'b0;
        end else begin
            state_q  <= state_nx;
            mode_q   <= mode_nx;
            idle_evt <= (state_nx == ST_IDLE) && (state_q != ST_IDLE);
        end
    end

    // Message word storage, one register per word
    for (genvar w = 0; w < MSG_WORDS; w++) begin : g_word
        // Store a data word, port A winning a collision
        always_ff @(posedge clk) begin
            if (!rst_n)
                data_q[w] <= '0;
            else if (a_dat_we && (int'(a_idx) == w))
                data_q[w] <= a_wdata;
            else if (b_dat_we && (int'(b_idx) == w))
                data_q[w] <= b_wdata;
        end
    end

    AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(state_q)); // R3

    AST_AUTO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        auto_rd && mode_q && !a_ctl_we && !b_ctl_we |=> state_q == ST_IDLE); // R7

    AST_BAD_STATE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        a_ctl_we && !a_st_ok && !b_ctl_we |=> $stable(state_q)); // R4 (and R8: auto return suppressed)

    AST_A_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        a_st_ok |=> state_q == $past(a_wdata[STATE_LSB +: 4])); // R9

    AST_IDLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        idle_evt |-> state_q == ST_IDLE && $past(state_q) != ST_IDLE); // R10

endmodule

// File: rtl/mbx_rdport.sv
`timescale 1ns/1ps
// Registered read path for one port: selects the addressed word from
// all slots and holds it until the next read on this port.
module mbx_rdport
    import mbx_pkg::*;
#(
    parameter int NUM_SLOTS = 2,
    parameter int MSG_WORDS = 8,
    parameter int IDX_W     = 3
) (
    input  logic                                           clk,
    input  logic                                           rst_n,
    input  logic                                           rd_en,
    input  logic [NUM_SLOTS-1:0]                           slot_sel,
    input  logic                                           ctl_hit,
    input  logic                                           dat_hit,
    input  logic [IDX_W-1:0]                               dat_idx,
    input  logic [NUM_SLOTS-1:0][3:0]                      st_all,
    input  logic [NUM_SLOTS-1:0]                           md_all,
    input  logic [NUM_SLOTS-1:0][MSG_WORDS-1:0][WORD_W-1:0] dat_all,
    output logic [WORD_W-1:0]                              rdata
);

    logic [WORD_W-1:0] rd_val;

    // Pick the addressed word; unused offsets give zero
    always_comb begin
        rd_val = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (slot_sel[s]) begin
                if (ctl_hit)
                    rd_val = ctl_image(st_all[s], md_all[s]);
                else if (dat_hit)
                    rd_val = dat_all[s][dat_idx];
            end
        end
    end

    // Capture on a read, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en)
            rdata <= rd_val;
    end

endmodule

// File: rtl/mbx_slot_bank.sv
`timescale 1ns/1ps
// Mailbox slot bank shared by an application port and a peer port.
// Each slot: control word (one-hot state, ack mode) plus MSG_WORDS data
// words in a SLOT_WORDS window. Writes take effect at the next edge;
// reads are registered. Peer reads of the last data word in automatic
// mode return the slot to idle.
module mbx_slot_bank
    import mbx_pkg::*;
#(
    parameter int NUM_SLOTS  = 2,
    parameter int SLOT_WORDS = 16,
    parameter int MSG_WORDS  = 8,
    localparam int OFS_W     = $clog2(SLOT_WORDS),
    localparam int SEL_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int ADDR_W    = OFS_W + SEL_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ap_req,
    input  logic                 ap_we,
    input  logic [ADDR_W-1:0]    ap_addr,
    input  logic [31:0]          ap_wdata,
    output logic [31:0]          ap_rdata,
    input  logic                 pr_req,
    input  logic                 pr_we,
    input  logic [ADDR_W-1:0]    pr_addr,
    input  logic [31:0]          pr_wdata,
    output logic [31:0]          pr_rdata,
    output logic [NUM_SLOTS-1:0] idle_evt
);

    localparam int IDX_W = $clog2(MSG_WORDS);

    logic [NUM_SLOTS-1:0] ap_sel, pr_sel;
    logic ap_ctl, ap_dat, ap_last, ap_unmapped;
    logic pr_ctl, pr_dat, pr_last, pr_unmapped;
    logic [IDX_W-1:0] ap_idx, pr_idx;

    logic [NUM_SLOTS-1:0][3:0]                       slot_st;
    logic [NUM_SLOTS-1:0]                            slot_md;
    logic [NUM_SLOTS-1:0][MSG_WORDS-1:0][WORD_W-1:0] slot_dat;

    mbx_decode #(
        .NUM_SLOTS(NUM_SLOTS), .SLOT_WORDS(SLOT_WORDS), .MSG_WORDS(MSG_WORDS),
        .ADDR_W(ADDR_W), .IDX_W(IDX_W)
    ) u_ap_dec (
        .req(ap_req), .addr(ap_addr), .slot_sel(ap_sel), .ctl_hit(ap_ctl),
        .dat_hit(ap_dat), .last_hit(ap_last), .dat_idx(ap_idx), .unmapped(ap_unmapped)
    );

    mbx_decode #(
        .NUM_SLOTS(NUM_SLOTS), .SLOT_WORDS(SLOT_WORDS), .MSG_WORDS(MSG_WORDS),
        .ADDR_W(ADDR_W), .IDX_W(IDX_W)
    ) u_pr_dec (
        .req(pr_req), .addr(pr_addr), .slot_sel(pr_sel), .ctl_hit(pr_ctl),
        .dat_hit(pr_dat), .last_hit(pr_last), .dat_idx(pr_idx), .unmapped(pr_unmapped)
    );

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        mbx_slot #(.MSG_WORDS(MSG_WORDS), .IDX_W(IDX_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .a_ctl_we (ap_sel[s] && ap_we && ap_ctl),
            .a_dat_we (ap_sel[s] && ap_we && ap_dat),
            .a_idx    (ap_idx),
            .a_wdata  (ap_wdata),
            .b_ctl_we (pr_sel[s] && pr_we && pr_ctl),
            .b_dat_we (pr_sel[s] && pr_we && pr_dat),
            .b_idx    (pr_idx),
            .b_wdata  (pr_wdata),
            .auto_rd  (pr_sel[s] && !pr_we && pr_last),
            .state_q  (slot_st[s]),
            .mode_q   (slot_md[s]),
            .data_q   (slot_dat[s]),
            .idle_evt (idle_evt[s])
        );

        AST_AP_NO_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
            ap_sel[s] && !ap_we && ap_last && !pr_sel[s] |=> $stable(slot_st[s])); // R7
    end

    mbx_rdport #(.NUM_SLOTS(NUM_SLOTS), .MSG_WORDS(MSG_WORDS), .IDX_W(IDX_W)) u_ap_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(ap_req && !ap_we), .slot_sel(ap_sel),
        .ctl_hit(ap_ctl), .dat_hit(ap_dat), .dat_idx(ap_idx),
        .st_all(slot_st), .md_all(slot_md), .dat_all(slot_dat), .rdata(ap_rdata)
    );

    mbx_rdport #(.NUM_SLOTS(NUM_SLOTS), .MSG_WORDS(MSG_WORDS), .IDX_W(IDX_W)) u_pr_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(pr_req && !pr_we), .slot_sel(pr_sel),
        .ctl_hit(pr_ctl), .dat_hit(pr_dat), .dat_idx(pr_idx),
        .st_all(slot_st), .md_all(slot_md), .dat_all(slot_dat), .rdata(pr_rdata)
    );

    AST_AP_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ap_req && !ap_we && ap_unmapped |=> ap_rdata == '0); // R6

    AST_PR_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        pr_req && !pr_we && pr_unmapped |=> pr_rdata == '0); // R6

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(ap_req && !ap_we) |=> $stable(ap_rdata)); // R2

endmodule

// File: tb/mbx_slot_bank_tb.sv
`timescale 1ns/1ps
// Bench: behavioural model updated at each rising edge, compared with
// both read ports and the idle pulses at every falling edge.
module mbx_slot_bank_tb;

    localparam int NS = 2;
    localparam int MW = 8;
    localparam int SW = 16;
    localparam int AW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic          ap_req = 1'b0, ap_we = 1'b0;
    logic [AW-1:0] ap_addr = '0;
    logic [31:0]   ap_wdata = '0;
    logic [31:0]   ap_rdata;
    logic          pr_req = 1'b0, pr_we = 1'b0;
    logic [AW-1:0] pr_addr = '0;
    logic [31:0]   pr_wdata = '0;
    logic [31:0]   pr_rdata;
    logic [NS-1:0] idle_evt;

    mbx_slot_bank #(.NUM_SLOTS(NS), .SLOT_WORDS(SW), .MSG_WORDS(MW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .ap_req(ap_req), .ap_we(ap_we), .ap_addr(ap_addr), .ap_wdata(ap_wdata), .ap_rdata(ap_rdata),
        .pr_req(pr_req), .pr_we(pr_we), .pr_addr(pr_addr), .pr_wdata(pr_wdata), .pr_rdata(pr_rdata),
        .idle_evt(idle_evt)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    string phase = "R1";
    bit    chk_en = 1'b0;

    // reference model state
    logic [3:0]  m_st  [NS];
    bit          m_md  [NS];
    logic [31:0] m_dat [NS][MW];
    logic [31:0] e_ap = '0, e_pr = '0;
    logic [NS-1:0] e_evt = '0;

    function automatic bit is_oh(logic [3:0] v);
        return (v == 4'h1) || (v == 4'h2) || (v == 4'h4) || (v == 4'h8);
    endfunction

    function automatic logic [31:0] m_read(logic [AW-1:0] a);
        int s = int'(a) / SW;
        int w = int'(a) % SW;
        if (s >= NS) return 32'h0;
        if (w == 0) return {24'h0, m_st[s], 3'b000, m_md[s]};
        if (w <= MW) return m_dat[s][w-1];
        return 32'h0;
    endfunction

    // model update at each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NS; s++) begin
                m_st[s] = 4'h1;
                m_md[s] = 1'b0;
                for (int w = 0; w < MW; w++) m_dat[s][w] = 32'h0;
            end
            e_ap = '0; e_pr = '0; e_evt = '0;
        end else begin
            if (ap_req && !ap_we) e_ap = m_read(ap_addr);
            if (pr_req && !pr_we) e_pr = m_read(pr_addr);
            for (int s = 0; s < NS; s++) begin
                logic [3:0] old;
                bit ac, pc, au;
                old = m_st[s];
                ac = ap_req && ap_we && (int'(ap_addr) == s*SW);
                pc = pr_req && pr_we && (int'(pr_addr) == s*SW);
                au = pr_req && !pr_we && (int'(pr_addr) == s*SW + MW);
                if (ac && is_oh(ap_wdata[7:4])) m_st[s] = ap_wdata[7:4];
                else if (pc && is_oh(pr_wdata[7:4])) m_st[s] = pr_wdata[7:4];
                else if (!ac && !pc && au && m_md[s]) m_st[s] = 4'h1;
                if (ac) m_md[s] = ap_wdata[0];
                else if (pc) m_md[s] = pr_wdata[0];
                for (int w = 0; w < MW; w++) begin
                    if (ap_req && ap_we && int'(ap_addr) == s*SW + 1 + w) m_dat[s][w] = ap_wdata;
                    else if (pr_req && pr_we && int'(pr_addr) == s*SW + 1 + w) m_dat[s][w] = pr_wdata;
                end
                e_evt[s] = (m_st[s] == 4'h1) && (old != 4'h1);
            end
        end
    end

    task automatic check(string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", phase, what, act, exp);
        end
    endtask

    // compare at every falling edge
    always @(negedge clk) begin
        if (chk_en) begin
            check("ap_rdata", ap_rdata, e_ap);
            check("pr_rdata", pr_rdata, e_pr);
            check("idle_evt", 32'(idle_evt), 32'(e_evt));
        end
    end

    task automatic drive(bit ar, bit aw, int aa, logic [31:0] ad,
                         bit pq, bit pw, int pa, logic [31:0] pd);
        ap_req = ar; ap_we = aw; ap_addr = AW'(aa); ap_wdata = ad;
        pr_req = pq; pr_we = pw; pr_addr = AW'(pa); pr_wdata = pd;
        @(negedge clk);
    endtask

    task automatic apw(int a, logic [31:0] d); drive(1, 1, a, d, 0, 0, 0, 0); endtask
    task automatic apr(int a);                 drive(1, 0, a, 0, 0, 0, 0, 0); endtask
    task automatic prw(int a, logic [31:0] d); drive(0, 0, 0, 0, 1, 1, a, d); endtask
    task automatic prr(int a);                 drive(0, 0, 0, 0, 1, 0, a, 0); endtask
    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk); @(negedge clk);
        chk_en = 1'b1;
        // R1: outputs during and right after reset
        phase = "R1";
        @(negedge clk);
        rst_n = 1'b1;
        for (int a = 0; a < 2*SW; a++) drive(1, 0, a, 0, 1, 0, 2*SW-1-a, 0);

        // R2: back-to-back reads on both ports, then hold
        phase = "R2";
        apw(1, 32'hA5A5_0001); prw(17, 32'h5A5A_0011);
        drive(1, 0, 1, 0, 1, 0, 17, 0);
        drive(1, 0, 17, 0, 1, 0, 1, 0);
        drive(1, 0, 0, 0, 1, 0, 16, 0);
        idle(3);

        // R3: control word layout, high bits dropped
        phase = "R3";
        apw(0, 32'hFFFF_FF21); apr(0); prr(0);
        apw(0, 32'h0000_0040); apr(0);

        // R4: non-one-hot state leaves state, mode still taken
        phase = "R4";
        apw(0, 32'h0000_0031); apr(0);
        prw(0, 32'h0000_0000); prr(0);
        apw(0, 32'h0000_00F1); apr(0);

        // R5: message through either port
        phase = "R5";
        apw(0, 32'h0000_0020);
        for (int i = 0; i < MW; i++) apw(1 + i, 32'hC0DE_0000 + i);
        for (int i = 0; i < MW; i++) prr(1 + i);
        for (int i = 0; i < MW; i++) prw(17 + i, 32'hBEEF_0000 + i);
        for (int i = 0; i < MW; i++) apr(17 + i);

        // R10: explicit return to idle pulses once; idle-to-idle does not
        phase = "R10";
        prw(0, 32'h0000_0010); apr(0);
        prw(0, 32'h0000_0010); idle(2);

        // R7: automatic return to idle on peer read of last word only
        phase = "R7";
        apw(16, 32'h0000_0021);
        for (int i = 0; i < MW; i++) apw(17 + i, 32'h1234_0000 + i);
        apr(24); apr(16);
        for (int i = 0; i < MW; i++) prr(17 + i);
        prr(16); idle(2);
        apw(0, 32'h0000_0020); prr(8); prr(0); idle(2);

        // R8: control write beats automatic return in the same cycle
        phase = "R8";
        apw(16, 32'h0000_0021);
        drive(1, 1, 16, 32'h0000_0081, 1, 0, 24, 0);
        apr(16);
        drive(1, 1, 16, 32'h0000_0071, 1, 0, 24, 0);
        apr(16); idle(2);

        // R9: same-word collisions keep the application port
        phase = "R9";
        drive(1, 1, 3, 32'h1111_1111, 1, 1, 3, 32'h2222_2222);
        apr(3);
        drive(1, 1, 0, 32'h0000_0030, 1, 1, 0, 32'h0000_0041);
        apr(0);
        drive(1, 1, 0, 32'h0000_0081, 1, 1, 0, 32'h0000_0040);
        prr(0);

        // R6: unused offsets and out-of-range words
        phase = "R6";
        for (int w = MW + 1; w < SW; w++) begin
            apw(w, 32'hDEAD_0000 + w);
            prw(SW + w, 32'hFEED_0000 + w);
        end
        for (int w = MW + 1; w < SW; w++) drive(1, 0, w, 0, 1, 0, SW + w, 0);
        for (int a = 0; a < 2*SW; a++) drive(1, 0, a, 0, 0, 0, 0, 0);

        // R11: random traffic on both ports across slots
        phase = "R11";
        for (int n = 0; n < 600; n++) begin
            bit ar, aw, pq, pw;
            int aa, pa;
            logic [31:0] ad, pd;
            ar = ($urandom_range(0, 3) != 0);
            aw = $urandom_range(0, 1) == 1;
            pq = ($urandom_range(0, 3) != 0);
            pw = $urandom_range(0, 1) == 1;
            aa = $urandom_range(0, 2*SW - 1);
            pa = ($urandom_range(0, 3) == 0) ? SW*$urandom_range(0, 1) + MW
                                             : $urandom_range(0, 2*SW - 1);
            ad = $urandom;
            pd = $urandom;
            if ((aa % SW) == 0) ad[7:4] = 4'h1 << $urandom_range(0, 4);
            if ((pa % SW) == 0) pd[7:4] = 4'h1 << $urandom_range(0, 4);
            drive(ar, aw, aa, ad, pq, pw, pa, pd);
        end
        idle(3);
        finish_run();
    end

endmodule